// File: doc/BRIEF.md
# Debug Command Frame Sequencer

Target-side engine for a serial debug port. The host shifts bits in, most significant bit first, one bit per cycle in which a valid strobe is high. The first eight bits form a command code. The engine then runs the rest of the frame for that command. This can be a 16-bit address sent by the host, write data sent by the host, a fixed wait of sixteen debug clock cycles, and read data that the engine shifts back out on a bit line with a valid flag.

The commands reach a byte-wide memory port, an 8-bit status/control register and a 16-bit breakpoint register. Commands that touch memory are intrusive, so they are accepted only while the core is halted. Status and breakpoint commands are accepted at any time. A command that is unknown, or refused by the halted check, is dropped. The engine then sets a sticky error flag and waits for the next command code.

The pulse-level line timing is outside this block, and so is the halt machinery. The halted state arrives as an input.

Top module: `dbg_frame_seq`

## Requirements
- R1: After reset, `out_vld_o`, `mem_re_o` and `mem_we_o` are low and `bkpt_o` and `ctrl_o` are zero. A status read then returns `{err=0, halted, 6'b0}`.
- R2: A bit is taken only in a cycle where `bit_vld_i` is high. A field's bits may be spread over cycles with idle gaps between them, and the field value is unchanged by the gaps.
- R3: Command 0xE4 returns the status byte in this layout: bit 7 is the sticky error flag, bit 6 is `halted_i`, bits 5:0 are the control bits. The eight bits come out MSB first on `bit_o`, with `out_vld_o` high, in consecutive cycles. The first bit appears in the cycle after the last command bit is taken.
- R4: Command 0xC4 takes 8 data bits. Bits 5:0 load the control bits (`ctrl_o`). Bit 7 = 1 clears the error flag. Bit 6 is ignored.
- R5: Command 0xC2 takes 16 bits into the breakpoint register (`bkpt_o`). Command 0xE2 returns those 16 bits MSB first.
- R6: Command 0xA8 takes a 16-bit address and then waits 16 cycles. In the 16th wait cycle `mem_re_o` pulses once, with `mem_addr_o` holding the address. The byte on `mem_rdata_i` in that cycle is shifted out MSB first, starting the next cycle.
- R7: Command 0x80 takes a 16-bit address and 8 data bits, then waits 16 cycles. In the 16th wait cycle `mem_we_o` pulses once, with the address and the data on the memory port. The engine then accepts a new command.
- R8: Opcodes with bit 6 clear (0xA8, 0x80) are accepted only if `halted_i` is high in the cycle the last command bit is taken. Otherwise they are dropped, the error flag is set, and no memory strobe follows. Opcodes with bit 6 set work while the core runs.
- R9: An opcode outside the six listed is dropped and sets the error flag. The next command is decoded normally.
- R10: The error flag stays set across later accepted commands until a 0xC4 write with bit 7 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debug clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halted_i | input | 1 | Core is halted in background mode |
| bit_vld_i | input | 1 | Host bit strobe |
| bit_i | input | 1 | Host-to-target bit |
| bit_o | output | 1 | Target-to-host bit |
| out_vld_o | output | 1 | `bit_o` carries a read bit this cycle |
| mem_addr_o | output | 16 | Memory access address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, sampled while `mem_re_o` is high |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| bkpt_o | output | 16 | Breakpoint register |
| ctrl_o | output | 6 | Control bits of the status/control register |

## Verification
The assertions check several rules on every cycle:
- a write strobe lasts one cycle and is followed by a return to command decode;
- a read strobe is followed at once by output-valid;
- a memory address phase starts only if the halted input was high at decode;
- the error flag rises only out of command decode;
- the wait counter signals completion only while it is running.

Only the bench scenarios can show the rest:
- the exact serial values;
- the sixteen-cycle wait position;
- gap tolerance in the input;
- the write-one-to-clear behaviour of the error flag;
- the control bit being ignored;
- rejection leaving the memory port untouched.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam logic [7:0] OP_RD_STAT = 8'hE4;
  localparam logic [7:0] OP_WR_CTRL = 8'hC4;
  localparam logic [7:0] OP_RD_BYTE = 8'hA8;
  localparam logic [7:0] OP_WR_BYTE = 8'h80;
  localparam logic [7:0] OP_RD_BKPT = 8'hE2;
  localparam logic [7:0] OP_WR_BKPT = 8'hC2;
  localparam int         BG_BIT     = 6;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_WDAT, S_WAIT, S_RDAT} seq_state_e;
endpackage

// File: rtl/dbg_rx_shift.sv
module dbg_rx_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  logic [W-2:0] q;

  // value including the bit arriving this cycle
  assign data_o = {q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (en_i) q <= data_o[W-2:0];
  end
endmodule

// File: rtl/dbg_tx_shift.sv
module dbg_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] q;

  assign msb_o = q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= data_i;
    else if (shift_i) q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/dbg_wait_ctr.sv
module dbg_wait_ctr #(
  parameter int N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R6
  wait_done_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(run_i));
endmodule

// File: rtl/dbg_frame_seq.sv
module dbg_frame_seq
  import dbg_seq_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int DATA_W   = 8,
  parameter int CMD_W    = 8,
  parameter int WAIT_CYC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               halted_i,
  input  logic               bit_vld_i,
  input  logic               bit_i,
  output logic               bit_o,
  output logic               out_vld_o,
  output logic [FIELD_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic               mem_re_o,
  output logic               mem_we_o,
  output logic [FIELD_W-1:0] bkpt_o,
  output logic [DATA_W-3:0]  ctrl_o
);
  localparam int CNT_W = $clog2(FIELD_W + 1);
  localparam int PAD_W = FIELD_W - DATA_W;

  seq_state_e          state_q, state_d;
  logic [CMD_W-1:0]    op_q;
  logic [CNT_W-1:0]    cnt_q, len_q, len_d;
  logic [FIELD_W-1:0]  addr_q, bkpt_q, rx_val, tx_val;
  logic [DATA_W-1:0]   wbyte_q, status;
  logic [DATA_W-3:0]   ctrl_q;
  logic                err_q;
  logic                take, adv, fld_done, tx_load, tx_msb, wait_done;
  logic                err_set, err_clr, ctrl_we, bkpt_we, addr_we, wbyte_we, op_we;
  logic [CMD_W-1:0]    cmd;
  logic                known, cmd_ok;

  assign take     = bit_vld_i && (state_q inside {S_CMD, S_ADDR, S_WDAT});
  assign adv      = take || (state_q == S_RDAT);
  assign fld_done = adv && (cnt_q == len_q - 1'b1);
  assign status   = {err_q, halted_i, ctrl_q};
  assign cmd      = rx_val[CMD_W-1:0];
  assign known    = cmd inside {OP_RD_STAT, OP_WR_CTRL, OP_RD_BYTE,
                                OP_WR_BYTE, OP_RD_BKPT, OP_WR_BKPT};
  // background-only class needs a halted core
  assign cmd_ok   = known && (cmd[BG_BIT] || halted_i);

  dbg_rx_shift #(.W(FIELD_W)) u_rx (
    .clk_i, .rst_ni, .en_i(take), .bit_i, .data_o(rx_val)
  );

  dbg_tx_shift #(.W(FIELD_W)) u_tx (
    .clk_i, .rst_ni, .load_i(tx_load), .data_i(tx_val),
    .shift_i(state_q == S_RDAT), .msb_o(tx_msb)
  );

  dbg_wait_ctr #(.N(WAIT_CYC)) u_wait (
    .clk_i, .rst_ni, .run_i(state_q == S_WAIT), .done_o(wait_done)
  );

  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    tx_load  = 1'b0;
    tx_val   = '0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    ctrl_we  = 1'b0;
    bkpt_we  = 1'b0;
    addr_we  = 1'b0;
    wbyte_we = 1'b0;
    op_we    = 1'b0;
    unique case (state_q)
      S_CMD: if (fld_done) begin
        op_we = 1'b1;
        len_d = CNT_W'(CMD_W);
        if (!cmd_ok) err_set = 1'b1;
        else begin
          case (cmd)
            OP_RD_STAT: begin
              tx_load = 1'b1; tx_val = {status, {PAD_W{1'b0}}};
              state_d = S_RDAT; len_d = CNT_W'(DATA_W);
            end
            OP_WR_CTRL: begin state_d = S_WDAT; len_d = CNT_W'(DATA_W);  end
            OP_RD_BYTE,
            OP_WR_BYTE: begin state_d = S_ADDR; len_d = CNT_W'(FIELD_W); end
            OP_RD_BKPT: begin
              tx_load = 1'b1; tx_val = bkpt_q;
              state_d = S_RDAT; len_d = CNT_W'(FIELD_W);
            end
            OP_WR_BKPT: begin state_d = S_WDAT; len_d = CNT_W'(FIELD_W); end
            default: ;
          endcase
        end
      end
      S_ADDR: if (fld_done) begin
        addr_we = 1'b1;
        if (op_q == OP_RD_BYTE) state_d = S_WAIT;
        else begin state_d = S_WDAT; len_d = CNT_W'(DATA_W); end
      end
      S_WDAT: if (fld_done) begin
        state_d = S_CMD;
        len_d   = CNT_W'(CMD_W);
        case (op_q)
          OP_WR_CTRL: begin ctrl_we = 1'b1; err_clr = rx_val[DATA_W-1]; end
          OP_WR_BKPT: bkpt_we = 1'b1;
          OP_WR_BYTE: begin wbyte_we = 1'b1; state_d = S_WAIT; end
          default: ;
        endcase
      end
      S_WAIT: if (wait_done) begin
        if (op_q == OP_RD_BYTE) begin
          tx_load = 1'b1; tx_val = {mem_rdata_i, {PAD_W{1'b0}}};
          state_d = S_RDAT; len_d = CNT_W'(DATA_W);
        end else begin
          state_d = S_CMD; len_d = CNT_W'(CMD_W);
        end
      end
      S_RDAT: if (fld_done) begin state_d = S_CMD; len_d = CNT_W'(CMD_W); end
      default: begin state_d = S_CMD; len_d = CNT_W'(CMD_W); end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_CMD;
      len_q   <= CNT_W'(CMD_W);
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wbyte_q <= '0;
      bkpt_q  <= '0;
      ctrl_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      if (adv)      cnt_q   <= fld_done ? '0 : cnt_q + 1'b1;
      if (op_we)    op_q    <= cmd;
      if (addr_we)  addr_q  <= rx_val;
      if (wbyte_we) wbyte_q <= rx_val[DATA_W-1:0];
      if (bkpt_we)  bkpt_q  <= rx_val;
      if (ctrl_we)  ctrl_q  <= rx_val[DATA_W-3:0];
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign out_vld_o   = (state_q == S_RDAT);
  assign bit_o       = out_vld_o & tx_msb;
  assign mem_re_o    = (state_q == S_WAIT) && wait_done && (op_q == OP_RD_BYTE);
  assign mem_we_o    = (state_q == S_WAIT) && wait_done && (op_q == OP_WR_BYTE);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wbyte_q;
  assign bkpt_o      = bkpt_q;
  assign ctrl_o      = ctrl_q;

  // R7
  we_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (!mem_we_o && state_q == S_CMD));
  // R6
  re_then_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> out_vld_o);
  // R8
  bg_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADDR && $past(state_q) == S_CMD) |-> $past(halted_i));
  // R10
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(state_q) == S_CMD);
endmodule

// File: tb/dbg_frame_seq_tb.sv
module dbg_frame_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halted = 1'b1;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_out, out_vld, mem_re, mem_we;
  logic [15:0] mem_addr, bkpt;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [5:0]  ctrl;
  int          n_chk = 0, n_err = 0, re_cnt = 0, we_cnt = 0;

  always #2 clk = ~clk;

  // memory model: data derived from address
  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;

  dbg_frame_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .halted_i(halted), .bit_vld_i(bit_vld),
    .bit_i(bit_in), .bit_o(bit_out), .out_vld_o(out_vld),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_re_o(mem_re), .mem_we_o(mem_we), .bkpt_o(bkpt), .ctrl_o(ctrl)
  );

  always @(posedge clk) begin
    if (mem_re) re_cnt++;
    if (mem_we) we_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] v, input int n, input int gap);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); bit_vld = 1'b1; bit_in = v[i];
      if (gap > 0) begin
        @(negedge clk); bit_vld = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    if (gap == 0) begin @(negedge clk); bit_vld = 1'b0; end
  endtask

  task automatic recv_bits(input int n, output logic [15:0] v, output logic vld_ok);
    v = '0; vld_ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (!out_vld) vld_ok = 1'b0;
      v = {v[14:0], bit_out};
      @(negedge clk);
    end
  endtask

  task automatic rd_stat(output logic [7:0] s);
    logic [15:0] v; logic ok;
    send_bits(16'hE4, 8, 0);
    recv_bits(8, v, ok);
    chk("R3 out_vld during status", {31'd0, ok}, 32'd1);
    s = v[7:0];
  endtask

  task automatic wr_ctrl(input logic [7:0] d);
    send_bits(16'hC4, 8, 0);
    send_bits({8'h00, d}, 8, 0);
  endtask

  // op[9:2], halted[1], expected error[0]
  localparam logic [9:0] VEC [6] = '{
    {8'h00, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b1},
    {8'hE0, 1'b0, 1'b1},
    {8'hA8, 1'b0, 1'b1},
    {8'h80, 1'b0, 1'b1},
    {8'hE4, 1'b0, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]  s;
    logic [15:0] v;
    logic        ok;
    int          re0, we0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_vld", {31'd0, out_vld}, 32'd0);
    chk("R1 mem_re", {31'd0, mem_re}, 32'd0);
    chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
    chk("R1 bkpt", {16'd0, bkpt}, 32'd0);
    chk("R1 ctrl", {26'd0, ctrl}, 32'd0);
    rd_stat(s);
    chk("R1 status", {24'd0, s}, 32'h40);

    // R8 R9 vector table
    foreach (VEC[k]) begin
      halted = 1'b1;
      wr_ctrl(8'h80);
      re0 = re_cnt; we0 = we_cnt;
      halted = VEC[k][1];
      if (VEC[k][9:2] == 8'hE4) begin
        send_bits({8'h00, VEC[k][9:2]}, 8, 0);
        recv_bits(8, v, ok);
        chk("R8 nonintrusive status while running", {24'd0, v[7:0]}, 32'h00);
      end else begin
        send_bits({8'h00, VEC[k][9:2]}, 8, 0);
      end
      repeat (20) @(negedge clk);
      chk("R8 no memory strobe after refusal", re_cnt + we_cnt, re0 + we0);
      rd_stat(s);
      chk("R9 error flag per vector", {31'd0, s[7]}, {31'd0, VEC[k][0]});
    end
    halted = 1'b1;

    // R4 control write, bit 6 ignored
    wr_ctrl(8'h80);
    wr_ctrl(8'h7F);
    chk("R4 ctrl bits", {26'd0, ctrl}, 32'h3F);
    rd_stat(s);
    chk("R4 status after ctrl write", {24'd0, s}, 32'h7F);

    // R10 sticky error
    send_bits(16'h11, 8, 0);
    wr_ctrl(8'h15);
    rd_stat(s);
    chk("R10 error survives write without bit7", {24'd0, s}, 32'hD5);
    rd_stat(s);
    chk("R10 error survives status read", {31'd0, s[7]}, 32'd1);
    wr_ctrl(8'h95);
    rd_stat(s);
    chk("R4 bit7 clears error", {24'd0, s}, 32'h55);

    // R5 + R2 breakpoint write with gaps
    send_bits(16'hC2, 8, 2);
    send_bits(16'hA5C3, 16, 3);
    chk("R2 R5 bkpt after gapped write", {16'd0, bkpt}, 32'hA5C3);
    send_bits(16'hE2, 8, 0);
    recv_bits(16, v, ok);
    chk("R5 bkpt readback", {16'd0, v}, 32'hA5C3);
    chk("R5 out_vld during bkpt read", {31'd0, ok}, 32'd1);
    send_bits(16'hC2, 8, 0);
    send_bits(16'h1234, 16, 0);
    send_bits(16'hE2, 8, 0);
    recv_bits(16, v, ok);
    chk("R5 bkpt second value", {16'd0, v}, 32'h1234);

    // R6 read byte with 16-cycle wait
    re0 = re_cnt;
    send_bits(16'hA8, 8, 0);
    send_bits(16'h3C71, 16, 0);
    for (int c = 1; c <= 16; c++) begin
      if (c < 16) chk("R6 no early read strobe", {31'd0, mem_re}, 32'd0);
      else begin
        chk("R6 read strobe in 16th wait cycle", {31'd0, mem_re}, 32'd1);
        chk("R6 read address", {16'd0, mem_addr}, 32'h3C71);
      end
      @(negedge clk);
    end
    recv_bits(8, v, ok);
    chk("R6 read data", {24'd0, v[7:0]}, {24'd0, 8'h71 ^ 8'h3C ^ 8'h5A});
    chk("R6 out_vld during read data", {31'd0, ok}, 32'd1);
    chk("R6 one read strobe", re_cnt - re0, 32'd1);

    // R7 write byte
    we0 = we_cnt;
    send_bits(16'h80, 8, 0);
    send_bits(16'h0102, 16, 0);
    send_bits(16'hE7, 8, 0);
    for (int c = 1; c <= 16; c++) begin
      if (c < 16) chk("R7 no early write strobe", {31'd0, mem_we}, 32'd0);
      else begin
        chk("R7 write strobe in 16th wait cycle", {31'd0, mem_we}, 32'd1);
        chk("R7 write address", {16'd0, mem_addr}, 32'h0102);
        chk("R7 write data", {24'd0, mem_wdata}, 32'hE7);
      end
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R7 one write strobe", we_cnt - we0, 32'd1);
    rd_stat(s);
    chk("R7 next command accepted", {24'd0, s}, 32'h55);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule